// File: doc/BRIEF.md
# Single-Cycle Load-Store Integer Core

This block is a 32-bit processor that finishes one instruction every clock cycle. It supports a small integer subset of a classic three-operand RISC encoding: register add, register subtract, add with a sign-extended immediate, word load and word store. Each cycle the program counter addresses an external instruction memory. The returned word is decoded into register-format or immediate-format fields. Operands are read from a 32-entry register file, and an adder produces either a result or an effective address. The write to the register file or to the data memory commits on the rising edge that ends the cycle.

Both memory ports are plain address/data ports. Read data is expected back in the same cycle, and stores are taken at the clock edge. Memory is byte-addressed and big-endian: bits 31:24 of a data word belong to the byte at the lowest address. Two registered status outputs report, one cycle after the offending instruction, an encoding outside the subset or a word access that is not aligned.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and both flags become 0.
- R2: Out of reset, `imem_addr` increases by 4 at every rising edge.
- R3: A word with opcode 0 and funct 32 writes rs+rt into rd. Opcode 0 with funct 34 writes rs-rt into rd. Both wrap modulo 2^32. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R4: Register 0 always reads as zero, and any write aimed at it is dropped.
- R5: Opcode 8 writes rs plus the sign-extended imm[15:0] into rt, so negative constants subtract.
- R6: Opcode 35 loads into rt the word at rs plus the sign-extended offset. The byte at the lowest address lands in bits 31:24.
- R7: Opcode 43 drives `dmem_we` high for that cycle, with `dmem_addr` set to rs plus the sign-extended offset and `dmem_wdata` set to rt. Bits 31:24 go to the lowest address.
- R8: A load or store whose effective address has non-zero bits 1:0 writes neither memory nor registers, and `misalign_flag` is high in the following cycle.
- R9: Any other encoding writes nothing, and `illegal_flag` is high in the following cycle.
- R10: An instruction reads the register values written by the instruction just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of a load or store |
| dmem_wdata | output | 32 | Store data, big-endian word |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| illegal_flag | output | 1 | Previous instruction was outside the subset |
| misalign_flag | output | 1 | Previous load or store was not word-aligned |

## Verification
The bench chains dependent instructions back to back, so a core that read a stale register would store the wrong sums. It loads a word whose four bytes differ, which exposes any swap of byte order, and it uses negative immediates and offsets, which a core that zero-extended would turn into huge values. It tries to write register 0 by both formats, and it issues misaligned loads and stores and unknown encodings. A core that let any of these through would disturb a register or memory byte that the bench later reads back. Last, it asserts reset in the middle of the run to confirm that the program counter restarts at zero.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int INSN_W = 32;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_ADDI, K_LW, K_SW, K_BAD
  } kind_e;
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RA_W = 5
) (
  input  logic [INSN_W-1:0] insn,
  output kind_e             kind,
  output logic [RA_W-1:0]   rs,
  output logic [RA_W-1:0]   rt,
  output logic [RA_W-1:0]   dst,
  output logic [XLEN-1:0]   imm,
  output logic              reg_wr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              use_imm
);
  logic [5:0] op, fn;
  assign op = insn[31:26];
  assign fn = insn[5:0];
  assign rs = insn[25:21];
  assign rt = insn[20:16];
  assign imm = {{(XLEN-16){insn[15]}}, insn[15:0]};

  always_comb begin
    kind = K_BAD;
    if (op == OP_REG && fn == FN_ADD)      kind = K_ADD;
    else if (op == OP_REG && fn == FN_SUB) kind = K_SUB;
    else if (op == OP_ADDI)                kind = K_ADDI;
    else if (op == OP_LW)                  kind = K_LW;
    else if (op == OP_SW)                  kind = K_SW;
  end

  assign dst     = (kind == K_ADD || kind == K_SUB) ? insn[15:11] : insn[20:16];
  assign reg_wr  = (kind == K_ADD) || (kind == K_SUB) || (kind == K_ADDI) || (kind == K_LW);
  assign mem_rd  = (kind == K_LW);
  assign mem_wr  = (kind == K_SW);
  assign use_imm = (kind == K_ADDI) || (kind == K_LW) || (kind == K_SW);
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RA_W-1:0] ra_a,
  input  logic [RA_W-1:0] ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] store [NREG];

  // entry 0 is never written; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (we && waddr != '0) store[waddr] <= wdata;
  end

  assign rd_a = (ra_a == '0) ? '0 : store[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : store[ra_b];
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] b_eff;
  assign b_eff = sub ? ~b : b;
  assign y = a + b_eff + {{(XLEN-1){1'b0}}, sub};
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int ALIGN_BITS = 2,
  localparam int RA_W = $clog2(NREG),
  localparam int STEP = 1 << ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic              illegal_flag,
  output logic              misalign_flag
);
  logic [XLEN-1:0] pc_q;
  kind_e           kind;
  logic [RA_W-1:0] rs, rt, dst;
  logic [XLEN-1:0] imm, va, vb, opb, sum, wb;
  logic            reg_wr, mem_rd, mem_wr, use_imm, unaligned;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + XLEN'(STEP);
  end
  assign imem_addr = pc_q;

  rcore_decode #(.XLEN(XLEN), .RA_W(RA_W)) u_dec (
    .insn(imem_rdata), .kind(kind), .rs(rs), .rt(rt), .dst(dst), .imm(imm),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .use_imm(use_imm)
  );

  rcore_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(reg_wr && !unaligned), .waddr(dst), .wdata(wb),
    .ra_a(rs), .ra_b(rt), .rd_a(va), .rd_b(vb)
  );

  assign opb = use_imm ? imm : vb;

  rcore_alu #(.XLEN(XLEN)) u_alu (
    .a(va), .b(opb), .sub(kind == K_SUB), .y(sum)
  );

  assign unaligned  = (mem_rd || mem_wr) && (sum[ALIGN_BITS-1:0] != '0);
  assign wb         = mem_rd ? dmem_rdata : sum;
  assign dmem_addr  = sum;
  assign dmem_wdata = vb;
  assign dmem_we    = mem_wr && !unaligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_flag  <= 1'b0;
      misalign_flag <= 1'b0;
    end else begin
      illegal_flag  <= (kind == K_BAD);
      misalign_flag <= unaligned;
    end
  end
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic [31:0] dmem_addr,
  input logic        dmem_we,
  input logic        illegal_flag,
  input logic        misalign_flag
);
  logic [1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 2'd0;
    else if (run_q != 2'd2) run_q <= run_q + 2'd1;
  end

  logic [5:0] op;
  logic       is_mem, legal;
  assign op     = imem_rdata[31:26];
  assign is_mem = (op == 6'd35) || (op == 6'd43);
  assign legal  = (op == 6'd0 && (imem_rdata[5:0] == 6'd32 || imem_rdata[5:0] == 6'd34))
               || op == 6'd8 || is_mem;

  a_r1_pc_restart: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr == 32'd0 && !illegal_flag && !misalign_flag));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (run_q != 2'd0) |-> imem_addr == $past(imem_addr) + 32'd4);

  a_r7_store_strobe: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == 6'd43 && dmem_addr[1:0] == 2'b00));

  a_r8_misalign_flag: assert property (@(posedge clk) disable iff (rst)
    (is_mem && dmem_addr[1:0] != 2'b00) |=> misalign_flag);

  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    !legal |=> (illegal_flag && !misalign_flag));
endmodule

bind rcore_top rcore_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_addr(dmem_addr), .dmem_we(dmem_we),
  .illegal_flag(illegal_flag), .misalign_flag(misalign_flag)
);

// File: tb/sim_rcore_top.sv
`timescale 1ns/1ps
module sim_rcore_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, illegal_flag, misalign_flag;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rcore_top u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .illegal_flag(illegal_flag), .misalign_flag(misalign_flag)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  // {insn, we, addr, wdata, illegal next, misalign next}
  function automatic logic [98:0] vec(logic [31:0] w, logic we, logic [31:0] a,
                                      logic [31:0] d, logic il, logic mi);
    return {w, we, a, d, il, mi};
  endfunction

  localparam int NV = 28;
  localparam logic [98:0] VEC [NV] = '{
    vec(enc_i(8, 0, 17, 5),      0, 0, 0, 0, 0),            // r17=5
    vec(enc_i(8, 0, 18, -3),     0, 0, 0, 0, 0),            // R5 r18=-3
    vec(enc_i(8, 0, 14, 99),     0, 0, 0, 0, 0),
    vec(enc_i(8, 0, 15, 77),     0, 0, 0, 0, 0),
    vec(enc_r(17, 18, 8, 32),    0, 0, 0, 0, 0),            // R3 add
    vec(enc_i(43, 0, 8, 0),      1, 0, 32'd2, 0, 0),        // R10 result used next
    vec(enc_r(17, 18, 9, 34),    0, 0, 0, 0, 0),            // R3 sub
    vec(enc_i(43, 0, 9, 4),      1, 4, 32'd8, 0, 0),
    vec(enc_r(18, 17, 10, 34),   0, 0, 0, 0, 0),            // R3 wrap
    vec(enc_i(43, 0, 10, 8),     1, 8, 32'hFFFF_FFF8, 0, 0),
    vec(enc_i(8, 0, 0, 7),       0, 0, 0, 0, 0),            // R4 write r0
    vec(enc_i(43, 0, 0, 12),     1, 12, 32'd0, 0, 0),
    vec(enc_r(17, 17, 0, 32),    0, 0, 0, 0, 0),            // R4 write r0
    vec(enc_i(43, 0, 0, 16),     1, 16, 32'd0, 0, 0),
    vec(enc_i(8, 0, 11, 16),     0, 0, 0, 0, 0),
    vec(enc_i(35, 11, 12, -12),  0, 0, 0, 0, 0),            // R6 load addr 4
    vec(enc_i(43, 0, 12, 20),    1, 20, 32'd8, 0, 0),
    vec(enc_i(35, 11, 13, 24),   0, 0, 0, 0, 0),            // R6 load addr 40
    vec(enc_i(43, 11, 13, -4),   1, 12, 32'h1122_3344, 0, 0),
    vec(enc_i(35, 11, 14, 2),    0, 0, 0, 0, 1),            // R8 load addr 18
    vec(enc_i(43, 0, 14, 24),    1, 24, 32'd99, 0, 0),
    vec(enc_i(43, 0, 17, 1),     0, 0, 0, 0, 1),            // R8 store addr 1
    vec(enc_r(17, 17, 15, 36),   0, 0, 0, 1, 0),            // R9 bad funct
    vec(enc_i(43, 0, 15, 28),    1, 28, 32'd77, 0, 0),
    vec(enc_i(4, 0, 15, 1),      0, 0, 0, 1, 0),            // R9 bad opcode
    vec(enc_i(43, 0, 15, 32),    1, 32, 32'd77, 0, 0),
    vec(enc_r(0, 17, 16, 32),    0, 0, 0, 0, 0),            // R4 read r0
    vec(enc_i(43, 0, 16, 36),    1, 36, 32'd5, 0, 0)
  };

  always_comb begin
    if ((imem_addr >> 2) < NV) imem_rdata = VEC[imem_addr >> 2][98:67];
    else                       imem_rdata = 32'h2000_0000;
  end

  logic [7:0] mem [64];
  logic [5:0] base;
  assign base = {dmem_addr[5:2], 2'b00};
  assign dmem_rdata = {mem[base], mem[base+6'd1], mem[base+6'd2], mem[base+6'd3]};
  always @(posedge clk) begin
    if (dmem_we) begin
      mem[base]      <= dmem_wdata[31:24];
      mem[base+6'd1] <= dmem_wdata[23:16];
      mem[base+6'd2] <= dmem_wdata[15:8];
      mem[base+6'd3] <= dmem_wdata[7:0];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 8'h00;
    mem[40] = 8'h11; mem[41] = 8'h22; mem[42] = 8'h33; mem[43] = 8'h44;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    check("R1 flags in reset", {30'd0, illegal_flag, misalign_flag}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      check("R2 pc", imem_addr, 32'(4 * i));
      check("R7 store strobe", {31'd0, dmem_we}, {31'd0, VEC[i][66]});
      if (VEC[i][66]) begin
        check("R7 store addr", dmem_addr, VEC[i][65:34]);
        check("R3 R4 R5 R6 R10 store data", dmem_wdata, VEC[i][33:2]);
      end
      if (i > 0) begin
        check("R9 illegal flag", {31'd0, illegal_flag}, {31'd0, VEC[i-1][1]});
        check("R8 misalign flag", {31'd0, misalign_flag}, {31'd0, VEC[i-1][0]});
      end
      @(posedge clk);
      @(negedge clk);
    end
    check("R9 illegal flag last", {31'd0, illegal_flag}, {31'd0, VEC[NV-1][1]});
    // big-endian byte placement and suppressed misaligned store
    check("R7 big-endian bytes", {mem[8], mem[9], mem[10], mem[11]}, 32'hFFFF_FFF8);
    check("R6 R7 loaded word bytes", {mem[12], mem[13], mem[14], mem[15]}, 32'h1122_3344);
    check("R8 no misaligned write", {mem[0], mem[1], mem[2], mem[3]}, 32'd2);
    // mid-run reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 pc after reset", imem_addr, 32'd0);
    check("R1 flags after reset", {30'd0, illegal_flag, misalign_flag}, 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 pc after release", imem_addr, 32'd4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule